// File: doc/BRIEF.md
# Timer Event Output Generator

This block turns the status strobes of a timer/counter core into single-cycle event pulses for the rest of the chip. The counter core reports when a counter cycle starts and ends, when it retriggers, when it hits its TOP or ZERO limit, and which of its compare/capture channels saw a hit. A separate flag marks the final cycle of a run. From these the block drives an overflow event, a retrigger event, one counter-cycle event and one event per channel. Each event only fires while its enable bit in a control word is set.

The counter-cycle event has a 2-bit position selector. It can fire at the start of every cycle, at the end of every cycle, only at the seam between two back-to-back cycles, or only at the outer edges of a run (the first start and the last end). The control word is loaded through a write strobe. The load is refused while the timer run input is high, so the event setup cannot change under a running timer. Every event is registered and appears exactly one clock after the strobe that causes it.

Top module: `tmr_evout_gen`

## Requirements
- R1: Channel event bit i (bit i of `ev_ch`) pulses high one clock after `stb_hit[i]` only when channel enable bit i (control word bits [NUM_CH-1:0]) is set. Each channel is gated on its own.
- R2: `ev_ovf` pulses one clock after `stb_top` or `stb_zero` only when the overflow enable (control bit NUM_CH) is set.
- R3: `ev_retrig` pulses one clock after `stb_retrig` only when the retrigger enable (control bit NUM_CH+1) is set.
- R4: While the cycle enable (control bit NUM_CH+2) is clear, `ev_cycle` never fires, whatever the selector and the strobes.
- R5: Selector value 0 (control bits [NUM_CH+4:NUM_CH+3]) makes `ev_cycle` follow `stb_begin`, and a lone `stb_end` gives nothing.
- R6: Selector value 1 makes `ev_cycle` follow `stb_end`, and a lone `stb_begin` gives nothing.
- R7: Selector value 2 fires only when `stb_end` and `stb_begin` are high in the same clock (one cycle hands over to the next). A lone end or a lone begin gives nothing.
- R8: Selector value 3 fires on a `stb_begin` that opens a run and on a `stb_end` seen together with `last_cycle`. A run opens at the first begin after reset or after such a final end. Begins and ends inside a run give nothing.
- R9: Reset clears every enable and the selector and drives all event outputs low, so strobes after reset make no events.
- R10: A write (`ctrl_wr`) while `run_en` is high leaves the control word unchanged. A write while `run_en` is low takes effect from the next clock.
- R11: Every event is registered: it is low in the clock of its strobe, high in the next, and low again after that once the strobe is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word load strobe |
| ctrl_wdata | input | NUM_CH+5 | Control word: channel enables, overflow/retrigger/cycle enables, selector |
| run_en | input | 1 | Timer running; blocks control loads while high |
| stb_begin | input | 1 | Counter cycle begins |
| stb_end | input | 1 | Counter cycle ends |
| stb_retrig | input | 1 | Counter retriggered |
| stb_top | input | 1 | Counter reached TOP |
| stb_zero | input | 1 | Counter reached ZERO |
| last_cycle | input | 1 | Current cycle is the last of the run |
| stb_hit | input | NUM_CH | Per-channel compare/capture hit |
| ev_ovf | output | 1 | Overflow/underflow event |
| ev_retrig | output | 1 | Retrigger event |
| ev_cycle | output | 1 | Counter-cycle event |
| ev_ch | output | NUM_CH | Per-channel match/capture events |

## Verification
The hardest case to reach is the boundary selector. Its result depends on whether a run is already open, and that state is set by strobes that came long before and is never visible at the ports. The bench does not rely on where the table left this state. It first closes any run with an end plus `last_cycle`. It then walks a fixed sequence of final end, opening begin, seamless handover, inner end, inner begin and final end, and checks that only the outer edges fire. The refused write is made visible by loading a full enable set, trying to clear it under `run_en`, and then watching that every event still fires.

// File: rtl/tmr_evout_pkg.sv
package tmr_evout_pkg;

    typedef enum logic [1:0] {
        CYC_AT_BEGIN  = 2'd0,
        CYC_AT_END    = 2'd1,
        CYC_AT_SEAM   = 2'd2,
        CYC_AT_EDGES  = 2'd3
    } cyc_sel_e;

    typedef struct packed {
        cyc_sel_e sel;
        logic     cyc_en;
        logic     rtg_en;
        logic     ovf_en;
    } misc_cfg_t;

    function automatic int ctrl_width(input int nch);
        return nch + 5;
    endfunction

    function automatic int ovf_bit(input int nch);
        return nch;
    endfunction

    function automatic int rtg_bit(input int nch);
        return nch + 1;
    endfunction

    function automatic int cyc_bit(input int nch);
        return nch + 2;
    endfunction

    function automatic int sel_lsb(input int nch);
        return nch + 3;
    endfunction

endpackage

// File: rtl/tmr_evout_cfg.sv
module tmr_evout_cfg
    import tmr_evout_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int CW = ctrl_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CW-1:0]     wdata,
    input  logic              run_en,
    output logic [CW-1:0]     word,
    output logic [NUM_CH-1:0] ch_en,
    output misc_cfg_t         misc
);

    localparam int OVF = ovf_bit(NUM_CH);
    localparam int RTG = rtg_bit(NUM_CH);
    localparam int CYC = cyc_bit(NUM_CH);
    localparam int SEL = sel_lsb(NUM_CH);

    logic [CW-1:0] cfg_q;
    logic          load;

    // A load is accepted only while the timer is stopped.
    assign load = wr & ~run_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= wdata;
        end
    end

    assign word       = cfg_q;
    assign ch_en      = cfg_q[NUM_CH-1:0];
    assign misc.ovf_en = cfg_q[OVF];
    assign misc.rtg_en = cfg_q[RTG];
    assign misc.cyc_en = cfg_q[CYC];
    assign misc.sel    = cyc_sel_e'(cfg_q[SEL+1:SEL]);

endmodule

// File: rtl/tmr_evout_cycle.sv
module tmr_evout_cycle
    import tmr_evout_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cyc_sel_e sel,
    input  logic     begin_s,
    input  logic     end_s,
    input  logic     last_s,
    output logic     fire
);

    logic in_run_q;
    logic final_end;
    logic in_run_eff;
    logic opening;

    assign final_end  = end_s & last_s;
    // A final end in this clock closes the run before a same-clock begin is judged.
    assign in_run_eff = in_run_q & ~final_end;
    assign opening    = begin_s & ~in_run_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_run_q <= 1'b0;
        end else if (begin_s) begin
            in_run_q <= 1'b1;
        end else if (final_end) begin
            in_run_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            CYC_AT_BEGIN: fire = begin_s;
            CYC_AT_END:   fire = end_s;
            CYC_AT_SEAM:  fire = end_s & begin_s;
            CYC_AT_EDGES: fire = opening | final_end;
            default:      fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_evout_pulse.sv
module tmr_evout_pulse #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] en,
    input  logic [W-1:0] trig,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= en[i] & trig[i];
            end
        end
    end

endmodule

// File: rtl/tmr_evout_gen.sv
module tmr_evout_gen
    import tmr_evout_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int CW = ctrl_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CW-1:0]     ctrl_wdata,
    input  logic              run_en,
    input  logic              stb_begin,
    input  logic              stb_end,
    input  logic              stb_retrig,
    input  logic              stb_top,
    input  logic              stb_zero,
    input  logic              last_cycle,
    input  logic [NUM_CH-1:0] stb_hit,
    output logic              ev_ovf,
    output logic              ev_retrig,
    output logic              ev_cycle,
    output logic [NUM_CH-1:0] ev_ch
);

    logic [CW-1:0]     cfg_word;
    logic [NUM_CH-1:0] ch_en;
    misc_cfg_t         misc;
    logic              cyc_fire;
    logic [2:0]        misc_en;
    logic [2:0]        misc_trig;
    logic [2:0]        misc_q;

    tmr_evout_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (ctrl_wr),
        .wdata  (ctrl_wdata),
        .run_en (run_en),
        .word   (cfg_word),
        .ch_en  (ch_en),
        .misc   (misc)
    );

    tmr_evout_cycle u_cycle (
        .clk     (clk),
        .rst     (rst),
        .sel     (misc.sel),
        .begin_s (stb_begin),
        .end_s   (stb_end),
        .last_s  (last_cycle),
        .fire    (cyc_fire)
    );

    tmr_evout_pulse #(.W(NUM_CH)) u_ch_pulse (
        .clk  (clk),
        .rst  (rst),
        .en   (ch_en),
        .trig (stb_hit),
        .q    (ev_ch)
    );

    assign misc_en   = {misc.cyc_en, misc.rtg_en, misc.ovf_en};
    assign misc_trig = {cyc_fire, stb_retrig, stb_top | stb_zero};

    tmr_evout_pulse #(.W(3)) u_misc_pulse (
        .clk  (clk),
        .rst  (rst),
        .en   (misc_en),
        .trig (misc_trig),
        .q    (misc_q)
    );

    assign ev_ovf    = misc_q[0];
    assign ev_retrig = misc_q[1];
    assign ev_cycle  = misc_q[2];

endmodule

// File: rtl/tmr_evout_chk.sv
module tmr_evout_chk
    import tmr_evout_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int CW = ctrl_width(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_wr,
    input logic              run_en,
    input logic              stb_begin,
    input logic              stb_end,
    input logic              stb_retrig,
    input logic              stb_top,
    input logic              stb_zero,
    input logic              last_cycle,
    input logic [NUM_CH-1:0] stb_hit,
    input logic              ev_ovf,
    input logic              ev_retrig,
    input logic              ev_cycle,
    input logic [NUM_CH-1:0] ev_ch,
    input logic [CW-1:0]     cfg_word
);

    localparam int OVF = ovf_bit(NUM_CH);
    localparam int RTG = rtg_bit(NUM_CH);
    localparam int CYC = cyc_bit(NUM_CH);
    localparam int SEL = sel_lsb(NUM_CH);

    logic [1:0] sel_w;
    assign sel_w = cfg_word[SEL+1:SEL];

    assert_ch_gated_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_ch & ~($past(stb_hit) & $past(cfg_word[NUM_CH-1:0]))) == '0);

    assert_ovf_src_R2: assert property (@(posedge clk) disable iff (rst)
        ev_ovf |-> ($past(stb_top | stb_zero) && $past(cfg_word[OVF])));

    assert_rtg_src_R3: assert property (@(posedge clk) disable iff (rst)
        ev_retrig |-> ($past(stb_retrig) && $past(cfg_word[RTG])));

    assert_cyc_off_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_word[CYC]) |-> !ev_cycle);

    assert_cyc_begin_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_w) == 2'd0 && ev_cycle) |-> $past(stb_begin));

    assert_cyc_end_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_w) == 2'd1 && ev_cycle) |-> $past(stb_end));

    assert_cyc_seam_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_w) == 2'd2 && ev_cycle) |-> $past(stb_end && stb_begin));

    assert_cyc_final_R8: assert property (@(posedge clk) disable iff (rst)
        $past(sel_w == 2'd3 && cfg_word[CYC] && stb_end && last_cycle) |-> ev_cycle);

    assert_reset_clear_R9: assert property (@(posedge clk)
        $past(rst) |-> (cfg_word == '0 && ev_ch == '0 && !ev_ovf && !ev_retrig && !ev_cycle));

    assert_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (run_en && ctrl_wr) |=> $stable(cfg_word));

endmodule

bind tmr_evout_gen tmr_evout_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .run_en     (run_en),
    .stb_begin  (stb_begin),
    .stb_end    (stb_end),
    .stb_retrig (stb_retrig),
    .stb_top    (stb_top),
    .stb_zero   (stb_zero),
    .last_cycle (last_cycle),
    .stb_hit    (stb_hit),
    .ev_ovf     (ev_ovf),
    .ev_retrig  (ev_retrig),
    .ev_cycle   (ev_cycle),
    .ev_ch      (ev_ch),
    .cfg_word   (cfg_word)
);

// File: tb/tmr_evout_gen_test.sv
`timescale 1ns/1ps
module tmr_evout_gen_test;

    localparam int NCH = 6;
    localparam int CW  = NCH + 5;
    localparam int NV  = 15;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ctrl_wr = 1'b0;
    logic [CW-1:0]  ctrl_wdata = '0;
    logic           run_en = 1'b0;
    logic           stb_begin = 1'b0, stb_end = 1'b0, stb_retrig = 1'b0;
    logic           stb_top = 1'b0, stb_zero = 1'b0, last_cycle = 1'b0;
    logic [NCH-1:0] stb_hit = '0;
    logic           ev_ovf, ev_retrig, ev_cycle;
    logic [NCH-1:0] ev_ch;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr_evout_gen #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .run_en(run_en), .stb_begin(stb_begin), .stb_end(stb_end),
        .stb_retrig(stb_retrig), .stb_top(stb_top), .stb_zero(stb_zero),
        .last_cycle(last_cycle), .stb_hit(stb_hit), .ev_ovf(ev_ovf),
        .ev_retrig(ev_retrig), .ev_cycle(ev_cycle), .ev_ch(ev_ch)
    );

    // Vector: ctrl{sel,cyc,rtg,ovf,ch[5:0]} | strobes{hit[5:0],begin,end,retrig,top,zero,last}
    //         | expected{ch[5:0],ovf,rtg,cyc} | requirement number
    localparam logic [35:0] VECS [NV] = '{
        {2'd0,1'b0,1'b0,1'b0,6'b111111, 6'b101010,6'b000000, 6'b101010,3'b000, 4'd1}, // R1
        {2'd0,1'b0,1'b0,1'b0,6'b000111, 6'b111111,6'b000000, 6'b000111,3'b000, 4'd1}, // R1
        {2'd0,1'b0,1'b0,1'b1,6'b000000, 6'b000000,6'b000100, 6'b000000,3'b100, 4'd2}, // R2 top
        {2'd0,1'b0,1'b0,1'b1,6'b000000, 6'b000000,6'b000010, 6'b000000,3'b100, 4'd2}, // R2 zero
        {2'd0,1'b0,1'b0,1'b0,6'b111111, 6'b000000,6'b000110, 6'b000000,3'b000, 4'd2}, // R2 off
        {2'd0,1'b0,1'b1,1'b0,6'b000000, 6'b000000,6'b001000, 6'b000000,3'b010, 4'd3}, // R3
        {2'd0,1'b0,1'b0,1'b1,6'b000000, 6'b000000,6'b001000, 6'b000000,3'b000, 4'd3}, // R3 off
        {2'd0,1'b0,1'b1,1'b1,6'b000000, 6'b000000,6'b110001, 6'b000000,3'b000, 4'd4}, // R4
        {2'd0,1'b1,1'b0,1'b0,6'b000000, 6'b000000,6'b100000, 6'b000000,3'b001, 4'd5}, // R5
        {2'd0,1'b1,1'b0,1'b0,6'b000000, 6'b000000,6'b010000, 6'b000000,3'b000, 4'd5}, // R5
        {2'd1,1'b1,1'b0,1'b0,6'b000000, 6'b000000,6'b010000, 6'b000000,3'b001, 4'd6}, // R6
        {2'd1,1'b1,1'b0,1'b0,6'b000000, 6'b000000,6'b100000, 6'b000000,3'b000, 4'd6}, // R6
        {2'd2,1'b1,1'b0,1'b0,6'b000000, 6'b000000,6'b110000, 6'b000000,3'b001, 4'd7}, // R7
        {2'd2,1'b1,1'b0,1'b0,6'b000000, 6'b000000,6'b010001, 6'b000000,3'b000, 4'd7}, // R7
        {2'd2,1'b1,1'b0,1'b0,6'b000000, 6'b000000,6'b100000, 6'b000000,3'b000, 4'd7}  // R7
    };

    function automatic logic [8:0] outs();
        return {ev_ch, ev_ovf, ev_retrig, ev_cycle};
    endfunction

    task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %09b expected %09b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [11:0] s);
        {stb_hit, stb_begin, stb_end, stb_retrig, stb_top, stb_zero, last_cycle} = s;
    endtask

    task automatic write_ctrl(input logic [CW-1:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    // Strobe for one clock; event must be absent now, present next, absent after (R11).
    task automatic pulse(input logic [11:0] s, input logic [8:0] exp, input string tag);
        @(negedge clk);
        drive(s);
        #1 check({tag, " R11 not yet"}, outs(), 9'b0);
        @(negedge clk);
        check(tag, outs(), exp);
        drive(12'b0);
        @(negedge clk);
        check({tag, " R11 one clock"}, outs(), 9'b0);
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state with strobes active during reset
        drive(12'hFFF);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(12'b0);
        check("R9 reset outputs", outs(), 9'b0);
        pulse(12'hFFF, 9'b0, "R9 no events after reset");

        for (int i = 0; i < NV; i++) begin
            write_ctrl(VECS[i][35:25]);
            pulse(VECS[i][24:13], VECS[i][12:4], $sformatf("R%0d vector %0d", VECS[i][3:0], i));
        end

        // R10: load under run_en is refused
        write_ctrl('0);
        run_en = 1'b1;
        write_ctrl({2'd0, 1'b1, 1'b1, 1'b1, 6'b111111});
        pulse({6'b111111, 6'b101110}, 9'b0, "R10 enable-all refused");
        run_en = 1'b0;
        write_ctrl({2'd0, 1'b1, 1'b1, 1'b1, 6'b111111});
        run_en = 1'b1;
        write_ctrl('0);
        pulse({6'b111111, 6'b101100}, 9'h1FF, "R10 clear refused");
        run_en = 1'b0;

        // R8: boundary selector, run state walked from a known point
        write_ctrl({2'd3, 1'b1, 1'b0, 1'b0, 6'b0});
        pulse({6'b0, 6'b010001}, 9'b001, "R8 final end");
        pulse({6'b0, 6'b100000}, 9'b001, "R8 opening begin");
        pulse({6'b0, 6'b110000}, 9'b000, "R8 inner handover");
        pulse({6'b0, 6'b010000}, 9'b000, "R8 inner end");
        pulse({6'b0, 6'b100000}, 9'b000, "R8 inner begin");
        pulse({6'b0, 6'b010001}, 9'b001, "R8 final end again");
        pulse({6'b0, 6'b110001}, 9'b001, "R8 final end with new begin");
        pulse({6'b0, 6'b010000}, 9'b000, "R8 run reopened");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule